// File: doc/BRIEF.md
# Register Save/Restore Descriptor Engine

This block runs one group of small bus programs held in an internal descriptor table. A descriptor names a bus address, carries a 32-bit data word, and gives an access width, an operation kind and one enable bit each for save and for restore. When started, the engine walks the table from a first index to a last index, or from the last back to the first. For each descriptor enabled for the current operation, it issues single-beat reads and writes on a simple bus master port.

The operation kinds are:
- copy: on save, read and keep the value; on restore, write the kept value back.
- fixed write.
- read-modify-write with OR or with AND.
- a pure delay.
- polling until masked read bits are all clear, or until any is set.

During a save, a copy descriptor stores its read value in its own data word. A later restore writes that word back. The engine stops at the first address-window violation, non-OKAY bus response or group timeout. It reports which error occurred and the index of the descriptor that failed. A one-cycle done pulse marks a clean finish.

The descriptor table is loaded through a plain write port while the engine is idle. Choosing between groups is left to the surrounding logic.

Top module: `regsr_engine`

## Requirements
- R1: Kind code 0 (copy): on save it reads the address and stores the size-masked read value into the descriptor's data word. On restore it writes that stored word to the address.
- R2: Kind code 1 writes the descriptor's data word to its address without reading first.
- R3: Kind code 2 reads, ORs the data word into the read value and writes the result back. Kind code 3 does the same with AND.
- R4: Kind code 4 issues no bus traffic and waits; a group holding only such a descriptor with data value N raises `done` N+4 clock edges after the edge that samples `start`.
- R5: Kind code 5 re-reads until (read AND data) is zero, and kind code 6 re-reads until it is non-zero. A new read beat follows each unsatisfied response.
- R6: Size code 0 means an 8-bit access, 1 a 16-bit access and 2 a 32-bit access, and `bus_size` carries this code. Read values and written values keep only the low 8 or 16 bits for the narrow sizes. `bus_req` stays high with a stable address and direction until `bus_ack`.
- R7: A descriptor whose enable bit for the current operation (`desc_save_en` for save, `desc_rest_en` for restore) is clear causes no bus access.
- R8: Walk order is chosen separately for each operation. With `save_reverse` or `rest_reverse` set (the latter used when `op_restore`=1), the walk runs from `last_idx` down to `first_idx`; otherwise it runs upward.
- R9: A non-delay descriptor whose address lies outside [`win_lo`, `win_hi`] sets `addr_err`, records its index in `err_idx` and ends the group with no further bus beats.
- R10: A beat acknowledged with `bus_resp_err` high sets `bus_fault`, records the index in `err_idx` and ends the group.
- R11: A non-zero `tmo_limit` bounds the number of busy cycles of the whole group; reaching it sets `tmo_err` and ends the group. Zero disables the limit.
- R12: `done` is a one-cycle pulse after the last descriptor of the walk completes with no error. All error flags clear when the next group starts.
- R13: After reset, `busy`, `done`, `bus_req` and all error flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| desc_we | input | 1 | Write one descriptor (ignored while busy) |
| desc_idx | input | IDX_W | Descriptor index to write |
| desc_addr | input | 32 | Target bus address |
| desc_data | input | 32 | Data word / operand / delay count / poll mask |
| desc_size | input | 2 | Access size code |
| desc_kind | input | 3 | Operation kind code |
| desc_save_en | input | 1 | Enable during save |
| desc_rest_en | input | 1 | Enable during restore |
| start | input | 1 | Start a group (sampled while idle) |
| op_restore | input | 1 | 1 = restore, 0 = save |
| first_idx | input | IDX_W | Lowest descriptor index of the group |
| last_idx | input | IDX_W | Highest descriptor index of the group |
| save_reverse | input | 1 | Walk downward during save |
| rest_reverse | input | 1 | Walk downward during restore |
| win_lo | input | 32 | Lowest legal bus address |
| win_hi | input | 32 | Highest legal bus address |
| tmo_limit | input | 32 | Group cycle limit, 0 = off |
| bus_req | output | 1 | Beat request |
| bus_we | output | 1 | 1 = write beat |
| bus_addr | output | 32 | Beat address |
| bus_size | output | 2 | Beat size code |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid with ack |
| bus_ack | input | 1 | Beat completes |
| bus_resp_err | input | 1 | Non-OKAY response, valid with ack |
| busy | output | 1 | Group in progress |
| done | output | 1 | Clean completion pulse |
| addr_err | output | 1 | Address window violation |
| bus_fault | output | 1 | Error response received |
| tmo_err | output | 1 | Group timeout |
| err_idx | output | IDX_W | Index of failing descriptor |

## Verification
The bus model acknowledges each beat one cycle after it sees a request, so a beat takes two cycles. Each write beat is compared against the scoreboard at the moment it is acknowledged, which checks order, address, size and data exactly when they are presented. Flags and `done` are registered. The bench therefore samples them on the falling edge after the rising edge on which they change. For a lone delay descriptor, it counts edges from `start` and expects `done` exactly N+4 edges later. Error runs are checked for the flag, the index, and an empty expected-write queue once the engine is idle.

// File: rtl/regsr_pkg.sv
package regsr_pkg;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;

  localparam logic [2:0] K_COPY  = 3'd0;
  localparam logic [2:0] K_FIXED = 3'd1;
  localparam logic [2:0] K_OR    = 3'd2;
  localparam logic [2:0] K_AND   = 3'd3;
  localparam logic [2:0] K_WAIT  = 3'd4;
  localparam logic [2:0] K_POLL0 = 3'd5;
  localparam logic [2:0] K_POLL1 = 3'd6;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    logic [1:0]        size;
    logic [2:0]        kind;
    logic              sv_en;
    logic              rt_en;
  } desc_t;

  localparam int DESC_W = $bits(desc_t);

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_EXEC, S_READ, S_WRITE, S_WAIT, S_NEXT
  } state_e;
endpackage

// File: rtl/regsr_desc_mem.sv
module regsr_desc_mem #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 70,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [IDX_W-1:0] raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    rdata <= store[raddr];
  end
endmodule

// File: rtl/regsr_alu.sv
module regsr_alu
  import regsr_pkg::*;
(
  input  logic [1:0]        size,
  input  logic [2:0]        kind,
  input  logic [DATA_W-1:0] rdata,
  input  logic [DATA_W-1:0] operand,
  output logic [DATA_W-1:0] rd_masked,
  output logic [DATA_W-1:0] wr_val,
  output logic              poll_met
);
  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] merged;
  logic              any_hit;

  always_comb begin
    case (size)
      2'd0:    mask = DATA_W'(32'h0000_00FF);
      2'd1:    mask = DATA_W'(32'h0000_FFFF);
      default: mask = '1;
    endcase
    rd_masked = rdata & mask;
    case (kind)
      K_OR:    merged = rd_masked | operand;
      K_AND:   merged = rd_masked & operand;
      default: merged = operand;
    endcase
    wr_val   = merged & mask;
    any_hit  = |(rd_masked & operand);
    poll_met = (kind == K_POLL0) ? !any_hit : any_hit;
  end
endmodule

// File: rtl/regsr_timeout.sv
module regsr_timeout #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             run,
  input  logic [CNT_W-1:0] limit,
  output logic             hit
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      limit_q <= '0;
    end else if (clear) begin
      cnt     <= '0;
      limit_q <= limit;
    end else if (run && cnt != '1) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign hit = (limit_q != '0) && (cnt >= limit_q);
endmodule

// File: rtl/regsr_engine.sv
module regsr_engine
  import regsr_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              desc_we,
  input  logic [IDX_W-1:0]  desc_idx,
  input  logic [ADDR_W-1:0] desc_addr,
  input  logic [DATA_W-1:0] desc_data,
  input  logic [1:0]        desc_size,
  input  logic [2:0]        desc_kind,
  input  logic              desc_save_en,
  input  logic              desc_rest_en,
  input  logic              start,
  input  logic              op_restore,
  input  logic [IDX_W-1:0]  first_idx,
  input  logic [IDX_W-1:0]  last_idx,
  input  logic              save_reverse,
  input  logic              rest_reverse,
  input  logic [ADDR_W-1:0] win_lo,
  input  logic [ADDR_W-1:0] win_hi,
  input  logic [31:0]       tmo_limit,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [1:0]        bus_size,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_ack,
  input  logic              bus_resp_err,
  output logic              busy,
  output logic              done,
  output logic              addr_err,
  output logic              bus_fault,
  output logic              tmo_err,
  output logic [IDX_W-1:0]  err_idx
);
  state_e            st;
  desc_t             d, q, st_desc, alu_d;
  logic [DESC_W-1:0] q_raw;
  logic [IDX_W-1:0]  cur, walk_end, st_idx;
  logic              restoring, reverse, st_we;
  logic [ADDR_W-1:0] lo_q, hi_q;
  logic [DATA_W-1:0] wcnt, rd_masked, wr_val;
  logic              poll_met, tmo_hit, mem_we, go, rev_now;
  logic [IDX_W-1:0]  mem_waddr;
  logic [DESC_W-1:0] mem_wdata;

  assign go      = start && (st == S_IDLE);
  assign rev_now = op_restore ? rest_reverse : save_reverse;

  assign mem_we    = st_we || (desc_we && !busy);
  assign mem_waddr = st_we ? st_idx : desc_idx;
  assign mem_wdata = st_we ? st_desc
                           : {desc_addr, desc_data, desc_size, desc_kind, desc_save_en, desc_rest_en};

  regsr_desc_mem #(.DEPTH(DEPTH), .WIDTH(DESC_W)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(cur), .rdata(q_raw)
  );
  assign q = desc_t'(q_raw);

  assign alu_d = (st == S_EXEC) ? q : d;
  regsr_alu u_alu (
    .size(alu_d.size), .kind(alu_d.kind), .rdata(bus_rdata), .operand(alu_d.data),
    .rd_masked(rd_masked), .wr_val(wr_val), .poll_met(poll_met)
  );

  regsr_timeout #(.CNT_W(32)) u_tmo (
    .clk(clk), .rst(rst), .clear(go), .run(busy), .limit(tmo_limit), .hit(tmo_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; busy <= 1'b0; done <= 1'b0;
      addr_err <= 1'b0; bus_fault <= 1'b0; tmo_err <= 1'b0; err_idx <= '0;
      bus_req <= 1'b0; bus_we <= 1'b0; bus_addr <= '0; bus_size <= '0; bus_wdata <= '0;
      cur <= '0; walk_end <= '0; restoring <= 1'b0; reverse <= 1'b0;
      lo_q <= '0; hi_q <= '0; wcnt <= '0; d <= '0;
      st_we <= 1'b0; st_idx <= '0; st_desc <= '0;
    end else begin
      done  <= 1'b0;
      st_we <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          busy <= 1'b1;
          addr_err <= 1'b0; bus_fault <= 1'b0; tmo_err <= 1'b0; err_idx <= '0;
          restoring <= op_restore;
          reverse   <= rev_now;
          cur       <= rev_now ? last_idx : first_idx;
          walk_end  <= rev_now ? first_idx : last_idx;
          lo_q <= win_lo; hi_q <= win_hi;
          st <= S_FETCH;
        end
        S_FETCH: st <= S_EXEC;
        S_EXEC: begin
          d <= q;
          if (!(restoring ? q.rt_en : q.sv_en) || q.kind > K_POLL1) begin
            st <= S_NEXT;
          end else if (q.kind == K_WAIT) begin
            wcnt <= q.data;
            st   <= S_WAIT;
          end else if (q.addr < lo_q || q.addr > hi_q) begin
            addr_err <= 1'b1; err_idx <= cur; busy <= 1'b0; st <= S_IDLE;
          end else begin
            bus_req  <= 1'b1;
            bus_addr <= q.addr;
            bus_size <= q.size;
            if (q.kind == K_FIXED || (q.kind == K_COPY && restoring)) begin
              bus_we <= 1'b1; bus_wdata <= wr_val; st <= S_WRITE;
            end else begin
              bus_we <= 1'b0; st <= S_READ;
            end
          end
        end
        S_READ: if (bus_ack) begin
          if (bus_resp_err) begin
            bus_fault <= 1'b1; err_idx <= cur; busy <= 1'b0; bus_req <= 1'b0; st <= S_IDLE;
          end else if (d.kind == K_COPY) begin
            st_we <= 1'b1; st_idx <= cur;
            st_desc <= '{addr: d.addr, data: rd_masked, size: d.size, kind: d.kind,
                         sv_en: d.sv_en, rt_en: d.rt_en};
            bus_req <= 1'b0; st <= S_NEXT;
          end else if (d.kind == K_OR || d.kind == K_AND) begin
            bus_we <= 1'b1; bus_wdata <= wr_val; st <= S_WRITE;
          end else if (poll_met) begin
            bus_req <= 1'b0; st <= S_NEXT;
          end
        end
        S_WRITE: if (bus_ack) begin
          bus_req <= 1'b0;
          if (bus_resp_err) begin
            bus_fault <= 1'b1; err_idx <= cur; busy <= 1'b0; st <= S_IDLE;
          end else begin
            st <= S_NEXT;
          end
        end
        S_WAIT: if (wcnt == '0) st <= S_NEXT; else wcnt <= wcnt - 1'b1;
        S_NEXT: if (cur == walk_end) begin
          done <= 1'b1; busy <= 1'b0; st <= S_IDLE;
        end else begin
          cur <= reverse ? cur - 1'b1 : cur + 1'b1;
          st  <= S_FETCH;
        end
        default: st <= S_IDLE;
      endcase
      if (busy && tmo_hit) begin
        tmo_err <= 1'b1; busy <= 1'b0; bus_req <= 1'b0; done <= 1'b0; st <= S_IDLE;
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R12
  AST_DONE_CLEAN: assert property (@(posedge clk) disable iff (rst)
    done |-> !(addr_err || bus_fault || tmo_err)); // R12
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst) !busy |-> !bus_req); // R12
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    bus_req && !bus_ack && !tmo_hit |=> bus_req && $stable(bus_addr) && $stable(bus_we)); // R6
  AST_WAIT_QUIET: assert property (@(posedge clk) disable iff (rst) st == S_WAIT |-> !bus_req); // R4
  AST_ADDR_ABORT: assert property (@(posedge clk) disable iff (rst)
    $rose(addr_err) |-> !busy && !bus_req); // R9
  AST_FAULT_ABORT: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_fault) |-> !busy && !bus_req); // R10
  AST_TMO_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    $rose(tmo_err) |-> $past(busy)); // R11
endmodule

// File: tb/regsr_engine_tb_top.sv
module regsr_engine_tb_top;
  localparam int DEPTH = 16;
  localparam int IW = $clog2(DEPTH);

  logic clk = 1'b0, rst = 1'b1;
  always #2 clk = ~clk;

  logic          desc_we = 0, desc_save_en = 0, desc_rest_en = 0;
  logic [IW-1:0] desc_idx = '0, first_idx = '0, last_idx = '0, err_idx;
  logic [31:0]   desc_addr = 0, desc_data = 0, win_lo = 0, win_hi = 32'h7FF, tmo_limit = 0;
  logic [1:0]    desc_size = 0, bus_size;
  logic [2:0]    desc_kind = 0;
  logic          start = 0, op_restore = 0, save_reverse = 0, rest_reverse = 0;
  logic          bus_req, bus_we, bus_ack = 0, bus_resp_err = 0;
  logic [31:0]   bus_addr, bus_wdata, bus_rdata = 0;
  logic          busy, done, addr_err, bus_fault, tmo_err;

  regsr_engine #(.DEPTH(DEPTH)) dut_i (.*);

  typedef struct { logic [31:0] addr; logic [31:0] data; logic [1:0] size; } exp_t;
  exp_t exp_q[$];
  logic [31:0] smem [logic [31:0]];
  int checks = 0, errors = 0, beats = 0, rd60 = 0, rd64 = 0;
  logic [1:0] rd20_size = 2'd3;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push_exp(input logic [31:0] a, input logic [31:0] v, input logic [1:0] s);
    exp_t e;
    e.addr = a; e.data = v; e.size = s;
    exp_q.push_back(e);
  endtask

  // Bus model and scoreboard monitor: one-cycle ack latency, write beats popped and compared.
  initial begin
    forever begin
      @(negedge clk);
      if (bus_req && !bus_ack) begin
        beats++;
        bus_resp_err = (bus_addr >= 32'h7F0);
        if (bus_we) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R7/R9 unexpected write", bus_addr, 32'h0);
          end else begin
            exp_t e;
            e = exp_q.pop_front();
            check(bus_addr == e.addr, "R8 write address", bus_addr, e.addr);
            check(bus_wdata == e.data, "R1/R2/R3 write data", bus_wdata, e.data);
            check(bus_size == e.size, "R6 write size", {30'h0, bus_size}, {30'h0, e.size});
          end
          smem[bus_addr] = bus_wdata;
        end else begin
          if (bus_addr == 32'h60) begin
            bus_rdata = (rd60 >= 2) ? 32'h1 : 32'h0;
            rd60++;
          end else begin
            if (bus_addr == 32'h64) rd64++;
            if (bus_addr == 32'h20) rd20_size = bus_size;
            bus_rdata = smem.exists(bus_addr) ? smem[bus_addr] : 32'h0;
          end
        end
        bus_ack = 1'b1;
      end else begin
        bus_ack = 1'b0;
        bus_resp_err = 1'b0;
      end
    end
  end

  task automatic load(input int idx, input logic [31:0] a, input logic [31:0] v,
                      input logic [1:0] s, input logic [2:0] k, input bit sv, input bit rt);
    @(negedge clk);
    desc_we = 1; desc_idx = IW'(idx); desc_addr = a; desc_data = v;
    desc_size = s; desc_kind = k; desc_save_en = sv; desc_rest_en = rt;
    @(negedge clk);
    desc_we = 0;
  endtask

  task automatic run(input bit rest, input int f, input int l, input bit srev, input bit rrev,
                     input logic [31:0] lim, output int cyc, output bit saw_done);
    @(negedge clk);
    op_restore = rest; first_idx = IW'(f); last_idx = IW'(l);
    save_reverse = srev; rest_reverse = rrev; tmo_limit = lim; start = 1;
    @(posedge clk);
    @(negedge clk);
    start = 0;
    cyc = 0; saw_done = 0;
    while (!done && !addr_err && !bus_fault && !tmo_err && cyc < 3000) begin
      @(posedge clk); @(negedge clk); cyc++;
    end
    saw_done = done;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int t0;
    for (int i = 0; i < 150000; i++) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int cyc; bit dn; int b0;
    repeat (3) @(negedge clk);
    // R13 reset state
    check(!busy && !done && !bus_req, "R13 reset outputs", {29'h0, busy, done, bus_req}, 32'h0);
    check(!addr_err && !bus_fault && !tmo_err, "R13 reset flags",
          {29'h0, addr_err, bus_fault, tmo_err}, 32'h0);
    @(negedge clk); rst = 0;

    smem[32'h20] = 32'h1234_5678;
    smem[32'h30] = 32'h1000_0001;
    smem[32'h40] = 32'h0000_ABCD;
    smem[32'h64] = 32'h0000_0000;
    load(0,  32'h10,  32'hAABB_CCDD, 2, 1, 1, 1);
    load(1,  32'h20,  32'h0,         1, 0, 1, 1);
    load(2,  32'h30,  32'h0000_0F00, 2, 2, 1, 0);
    load(3,  32'h40,  32'h0000_00FF, 0, 3, 1, 0);
    load(4,  32'h0,   32'd5,         2, 4, 1, 1);
    load(5,  32'h50,  32'h77,        2, 1, 0, 1);
    load(6,  32'h60,  32'h1,         2, 6, 1, 0);
    load(7,  32'h64,  32'h1,         2, 5, 1, 0);
    load(8,  32'h900, 32'h1,         2, 1, 1, 0);
    load(9,  32'h70,  32'h2,         2, 1, 1, 0);
    load(10, 32'h7F0, 32'h3,         2, 1, 1, 0);
    load(11, 32'h74,  32'h4,         2, 1, 1, 0);
    load(12, 32'h68,  32'h1,         2, 6, 1, 0);

    // Save forward 0..5: fixed write, copy read, OR, AND (8-bit), delay, restore-only skipped
    push_exp(32'h10, 32'hAABB_CCDD, 2);   // R2
    push_exp(32'h30, 32'h1000_0F01, 2);   // R3 OR
    push_exp(32'h40, 32'h0000_00CD, 0);   // R3 AND, R6 8-bit mask
    run(0, 0, 5, 0, 0, 0, cyc, dn);
    check(dn, "R12 done after clean save", {31'h0, dn}, 32'h1);
    check(exp_q.size() == 0, "R3 all save writes seen", exp_q.size(), 0);
    check(rd20_size == 2'd1, "R6 16-bit read size", {30'h0, rd20_size}, 32'h1);
    check(!done, "R12 done is one cycle", {31'h0, done}, 32'h0);

    // Restore reversed 5..0: order 5,1,0; 2 and 3 save-only skipped; stored copy value
    push_exp(32'h50, 32'h0000_0077, 2);   // R8 first in reverse walk
    push_exp(32'h20, 32'h0000_5678, 1);   // R1 stored 16-bit value written back
    push_exp(32'h10, 32'hAABB_CCDD, 2);
    run(1, 0, 5, 0, 1, 0, cyc, dn);
    check(dn, "R1 restore completes", {31'h0, dn}, 32'h1);
    check(exp_q.size() == 0, "R7 skipped descriptors and R8 order", exp_q.size(), 0);

    // Save reversed 2..3: AND write before OR write
    push_exp(32'h40, 32'h0000_00CD, 0);
    push_exp(32'h30, 32'h1000_0F01, 2);
    run(0, 2, 3, 1, 0, 0, cyc, dn);
    check(dn && exp_q.size() == 0, "R8 save reverse order", exp_q.size(), 0);

    // Lone delay: done exactly N+4 edges after start, no beats
    b0 = beats;
    run(0, 4, 4, 0, 0, 0, cyc, dn);
    check(dn && cyc == 9, "R4 delay length", cyc, 9);
    check(beats == b0, "R4 no bus beats during delay", beats - b0, 0);

    // Polls: poll-until-set needs three reads, poll-until-clear one read
    run(0, 6, 7, 0, 0, 0, cyc, dn);
    check(dn, "R5 poll group completes", {31'h0, dn}, 32'h1);
    check(rd60 == 3, "R5 poll-until-set reads", rd60, 3);
    check(rd64 == 1, "R5 poll-until-clear reads", rd64, 1);

    // Address window error at index 8; index 9 must not be written
    run(0, 8, 9, 0, 0, 0, cyc, dn);
    check(addr_err && !dn, "R9 address error flag", {31'h0, addr_err}, 32'h1);
    check(err_idx == IW'(8), "R9 error index", {28'h0, err_idx}, 32'd8);
    check(!busy && exp_q.size() == 0, "R9 group stopped", {31'h0, busy}, 32'h0);

    // Bus error response at index 10; index 11 not written
    push_exp(32'h7F0, 32'h3, 2);
    run(0, 10, 11, 0, 0, 0, cyc, dn);
    check(bus_fault && !dn, "R10 bus fault flag", {31'h0, bus_fault}, 32'h1);
    check(err_idx == IW'(10), "R10 error index", {28'h0, err_idx}, 32'd10);
    check(!addr_err, "R12 flags cleared on new start", {31'h0, addr_err}, 32'h0);
    check(exp_q.size() == 0, "R10 no writes after fault", exp_q.size(), 0);

    // Timeout on a never-satisfied poll; limit 0 leaves the delay group untouched
    run(0, 12, 12, 0, 0, 32'd40, cyc, dn);
    check(tmo_err && !dn, "R11 timeout flag", {31'h0, tmo_err}, 32'h1);
    check(!busy && !bus_req, "R11 group stopped", {30'h0, busy, bus_req}, 32'h0);
    run(0, 4, 4, 0, 0, 32'd0, cyc, dn);
    check(dn && !tmo_err, "R11 zero limit disables timeout", {31'h0, tmo_err}, 32'h0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule